// File: doc/BRIEF.md
# CompactFlash Sector Read Sequencer

This block is a bus master that pulls a run of 512-byte sectors out of a CompactFlash host controller reached through a 16-bit register port. A single start pulse hands it a 28-bit starting LBA and a sector count. The sequencer then takes the controller's host lock and polls until the card reports that it can accept a command. It splits the request into commands of at most `CHUNK_MAX` sectors and reads each sector as sixteen 32-byte buffers of sixteen words each. The bytes leave on a valid/ready stream. At the end the lock is handed back and the result is reported as a completion pulse with a 2-bit code.

Register accesses use a request/acknowledge handshake. Address, direction and write data are held stable from the first request cycle until the acknowledge. All polling gaps are expressed in microseconds and scaled by `CYC_PER_US`, so a bench can shrink them. When the downstream consumer stalls, further buffer reads stall with it, so no word is ever dropped.

Top module: `cf_sector_reader`

## Requirements
- R1: After reset the block is idle, with no register request, no byte valid and busy low. On start it reads the control register (offset 0x18) and writes it back with bit 1 (lock request) set, preserving the other bits. It then polls the status register (offset 0x04) until status bit 1 (lock granted) is set. A pending register request keeps its address, direction and data until acknowledged.
- R2: If the lock is not granted after `LOCK_RETRIES`+1 status polls, the run ends without any further register write. The error code is 1 (lock timeout) when status bit 4 (card detect) was set in the last poll, and 2 (card absent) when it was clear.
- R3: Once locked, status bit 8 (ready for command) is polled. If card detect is clear in any such poll, the run ends with code 2. If the ready bit is still clear after `RDY_RETRIES`+1 polls, the run ends with code 3 (not ready). In both cases the lock is released.
- R4: A request is split into commands of at most `CHUNK_MAX` sectors. The LBA advances by each command's sector count.
- R5: For each command, the low 16 LBA bits are written to offset 0x10, and then LBA bits 27:16 are written to offset 0x12 with bits 15:12 zero.
- R6: The command word written to offset 0x14 carries 0x03 in bits 15:8 and the command's sector count in bits 7:0. A count of 256 is encoded as 0.
- R7: After each command, the control register is read and written back with bit 7 (controller reset) set. After the command's last word it is read again and written back with bit 7 cleared.
- R8: Each 32-byte buffer is preceded by status polls until bit 5 (buffer ready) is set, and is then read as 16 word reads of offset 0x40. A sector spans 16 buffers.
- R9: Each word leaves as its low byte and then its high byte. The byte and valid hold while ready is low. No data word is read while a byte is still pending.
- R10: At the end of a successful run, including a count of 0, the control register is read and written back with bit 1 cleared. `done_o` pulses for one cycle only after the last byte has been accepted. `err_code_o` holds the result (0 = success) until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| lba_i | input | LBA_W | First sector address |
| count_i | input | CNT_W | Number of sectors |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_code_o | output | 2 | 0 ok, 1 lock timeout, 2 card absent, 3 not ready |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 7 | Byte offset of the register |
| reg_wdata_o | output | 16 | Write data |
| reg_ack_i | input | 1 | Access complete |
| reg_rdata_i | input | 16 | Read data, valid with ack |
| byte_valid_o | output | 1 | Output byte valid |
| byte_data_o | output | 8 | Output byte |
| byte_ready_i | input | 1 | Consumer accepts byte |

## Verification
The assertions cover the rules that hold at every clock edge:
- Requests held until acknowledged.
- The mask on the high LBA word and the fixed command code.
- No data-register write, and no data read while a byte is pending.
- Bytes held under back-pressure.
- Completion only after the stream has drained.

The ordering claims need the bench's scenarios, which compare every register write and every streamed byte against a model. These claims are the sequence of control read-modify-writes, the LBA carry across chunk boundaries, the count encoding, the status-poll counts before each timeout, and the error code chosen on each exit path.

// File: rtl/cf_rd_pkg.sv
package cf_rd_pkg;
  localparam logic [6:0] OFS_STAT   = 7'h04;
  localparam logic [6:0] OFS_LBA_LO = 7'h10;
  localparam logic [6:0] OFS_LBA_HI = 7'h12;
  localparam logic [6:0] OFS_CMD    = 7'h14;
  localparam logic [6:0] OFS_CTRL   = 7'h18;
  localparam logic [6:0] OFS_DATA   = 7'h40;

  localparam int ST_LOCK = 1;
  localparam int ST_CARD = 4;
  localparam int ST_BUF  = 5;
  localparam int ST_RDY  = 8;

  localparam logic [15:0] M_LOCK = 16'h0002;
  localparam logic [15:0] M_CRST = 16'h0080;
  localparam logic [7:0]  CMD_READ = 8'h03;

  typedef enum logic [1:0] {
    ERR_NONE, ERR_LOCK, ERR_ABSENT, ERR_NOT_READY
  } err_e;

  typedef enum logic [4:0] {
    S_IDLE, S_LK_RD, S_LK_WR, S_LK_POLL, S_LK_WAIT, S_RY_POLL, S_RY_WAIT,
    S_LBA_LO, S_LBA_HI, S_CMD, S_RST_RD, S_RST_WR, S_BUF_POLL, S_BUF_WAIT,
    S_BUF_RD, S_CLR_RD, S_CLR_WR, S_REL_RD, S_REL_WR, S_FIN
  } state_e;
endpackage

// File: rtl/cf_gap_timer.sv
module cf_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] len_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  // preloads while idle, so a wait lasts exactly len_i cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/cf_word_to_bytes.sv
module cf_word_to_bytes (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [15:0] in_word_i,
  output logic        in_ready_o,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  input  logic        out_ready_i
);
  logic [15:0] word_q;
  logic [1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      left_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      word_q <= in_word_i;
      left_q <= 2'd2;
    end else if (out_valid_o && out_ready_i) begin
      left_q <= left_q - 2'd1;
    end
  end

  assign in_ready_o  = (left_q == 2'd0);
  assign out_valid_o = (left_q != 2'd0);
  assign out_data_o  = (left_q == 2'd2) ? word_q[7:0] : word_q[15:8];
endmodule

// File: rtl/cf_sector_reader.sv
module cf_sector_reader
  import cf_rd_pkg::*;
#(
  parameter int CYC_PER_US   = 100,
  parameter int LOCK_RETRIES = 10,
  parameter int LOCK_GAP_US  = 100000,
  parameter int RDY_RETRIES  = 2000,
  parameter int RDY_GAP_US   = 1000,
  parameter int BUF_GAP_US   = 100,
  parameter int CHUNK_MAX    = 256,
  parameter int CNT_W        = 16,
  parameter int LBA_W        = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LBA_W-1:0] lba_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_code_o,
  output logic             reg_req_o,
  output logic             reg_we_o,
  output logic [6:0]       reg_addr_o,
  output logic [15:0]      reg_wdata_o,
  input  logic             reg_ack_i,
  input  logic [15:0]      reg_rdata_i,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  input  logic             byte_ready_i
);
  localparam int LOCK_GAP  = LOCK_GAP_US * CYC_PER_US;
  localparam int RDY_GAP   = RDY_GAP_US * CYC_PER_US;
  localparam int BUF_GAP   = BUF_GAP_US * CYC_PER_US;
  localparam int GAP_MAX   = (LOCK_GAP > RDY_GAP) ? ((LOCK_GAP > BUF_GAP) ? LOCK_GAP : BUF_GAP)
                                                  : ((RDY_GAP > BUF_GAP) ? RDY_GAP : BUF_GAP);
  localparam int TMR_W     = $clog2(GAP_MAX + 1);
  localparam int TRY_MAX   = (LOCK_RETRIES > RDY_RETRIES) ? LOCK_RETRIES : RDY_RETRIES;
  localparam int TRY_W     = $clog2(TRY_MAX + 1);
  localparam int CHUNK_W   = $clog2(CHUNK_MAX + 1);
  localparam int BUF_W     = $clog2(CHUNK_MAX * 16 + 1);

  state_e             state_q;
  err_e               err_q;
  logic [LBA_W-1:0]   lba_q;
  logic [CNT_W-1:0]   remain_q;
  logic [CHUNK_W-1:0] chunk_q, chunk_n;
  logic [BUF_W-1:0]   bufs_q;
  logic [3:0]         widx_q;
  logic [TRY_W-1:0]   tries_q;
  logic [15:0]        ctrl_q;
  logic               acc, ser_ready, tmr_run, tmr_exp;
  logic [TMR_W-1:0]   tmr_len;

  assign acc     = reg_req_o && reg_ack_i;
  assign chunk_n = (remain_q > CNT_W'(CHUNK_MAX)) ? CHUNK_W'(CHUNK_MAX) : CHUNK_W'(remain_q);

  // wait length follows the poll group that precedes the wait
  assign tmr_run = (state_q == S_LK_WAIT) || (state_q == S_RY_WAIT) || (state_q == S_BUF_WAIT);
  always_comb begin
    case (state_q)
      S_LK_POLL, S_LK_WAIT: tmr_len = TMR_W'(LOCK_GAP);
      S_RY_POLL, S_RY_WAIT: tmr_len = TMR_W'(RDY_GAP);
      default:              tmr_len = TMR_W'(BUF_GAP);
    endcase
  end

  cf_gap_timer #(.W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .run_i(tmr_run), .len_i(tmr_len), .expired_o(tmr_exp)
  );

  cf_word_to_bytes u_ser (
    .clk_i, .rst_ni,
    .in_valid_i (state_q == S_BUF_RD && acc),
    .in_word_i  (reg_rdata_i),
    .in_ready_o (ser_ready),
    .out_valid_o(byte_valid_o),
    .out_data_o (byte_data_o),
    .out_ready_i(byte_ready_i)
  );

  always_comb begin
    reg_req_o   = 1'b0;
    reg_we_o    = 1'b0;
    reg_addr_o  = OFS_STAT;
    reg_wdata_o = '0;
    case (state_q)
      S_LK_RD, S_RST_RD, S_CLR_RD, S_REL_RD: begin
        reg_req_o = 1'b1; reg_addr_o = OFS_CTRL;
      end
      S_LK_WR:  begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = OFS_CTRL; reg_wdata_o = ctrl_q | M_LOCK;  end
      S_RST_WR: begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = OFS_CTRL; reg_wdata_o = ctrl_q | M_CRST;  end
      S_CLR_WR: begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = OFS_CTRL; reg_wdata_o = ctrl_q & ~M_CRST; end
      S_REL_WR: begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = OFS_CTRL; reg_wdata_o = ctrl_q & ~M_LOCK; end
      S_LK_POLL, S_RY_POLL, S_BUF_POLL: reg_req_o = 1'b1;
      S_LBA_LO: begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = OFS_LBA_LO; reg_wdata_o = lba_q[15:0]; end
      S_LBA_HI: begin
        reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = OFS_LBA_HI;
        reg_wdata_o = 16'(lba_q[LBA_W-1:16]) & 16'h0FFF;
      end
      S_CMD:    begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = OFS_CMD; reg_wdata_o = {CMD_READ, 8'(chunk_q)}; end
      S_BUF_RD: begin reg_req_o = ser_ready; reg_addr_o = OFS_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      err_q    <= ERR_NONE;
      lba_q    <= '0;
      remain_q <= '0;
      chunk_q  <= '0;
      bufs_q   <= '0;
      widx_q   <= '0;
      tries_q  <= '0;
      ctrl_q   <= '0;
    end else begin
      if (acc && reg_addr_o == OFS_CTRL) ctrl_q <= reg_we_o ? reg_wdata_o : reg_rdata_i;
      case (state_q)
        S_IDLE: if (start_i) begin
          lba_q <= lba_i; remain_q <= count_i; err_q <= ERR_NONE; state_q <= S_LK_RD;
        end
        S_LK_RD: if (acc) state_q <= S_LK_WR;
        S_LK_WR: if (acc) begin tries_q <= '0; state_q <= S_LK_POLL; end
        S_LK_POLL: if (acc) begin
          if (reg_rdata_i[ST_LOCK]) begin
            tries_q <= '0; state_q <= S_RY_POLL;
          end else if (tries_q == TRY_W'(LOCK_RETRIES)) begin
            err_q <= reg_rdata_i[ST_CARD] ? ERR_LOCK : ERR_ABSENT; state_q <= S_FIN;
          end else begin
            tries_q <= tries_q + 1'b1; state_q <= S_LK_WAIT;
          end
        end
        S_LK_WAIT: if (tmr_exp) state_q <= S_LK_POLL;
        S_RY_POLL: if (acc) begin
          if (!reg_rdata_i[ST_CARD]) begin
            err_q <= ERR_ABSENT; state_q <= S_REL_RD;
          end else if (reg_rdata_i[ST_RDY]) begin
            state_q <= (remain_q == '0) ? S_REL_RD : S_LBA_LO;
          end else if (tries_q == TRY_W'(RDY_RETRIES)) begin
            err_q <= ERR_NOT_READY; state_q <= S_REL_RD;
          end else begin
            tries_q <= tries_q + 1'b1; state_q <= S_RY_WAIT;
          end
        end
        S_RY_WAIT: if (tmr_exp) state_q <= S_RY_POLL;
        S_LBA_LO: if (acc) begin
          chunk_q <= chunk_n; bufs_q <= BUF_W'(chunk_n) << 4; state_q <= S_LBA_HI;
        end
        S_LBA_HI: if (acc) state_q <= S_CMD;
        S_CMD:    if (acc) state_q <= S_RST_RD;
        S_RST_RD: if (acc) state_q <= S_RST_WR;
        S_RST_WR: if (acc) state_q <= S_BUF_POLL;
        S_BUF_POLL: if (acc) begin
          widx_q  <= '0;
          state_q <= reg_rdata_i[ST_BUF] ? S_BUF_RD : S_BUF_WAIT;
        end
        S_BUF_WAIT: if (tmr_exp) state_q <= S_BUF_POLL;
        S_BUF_RD: if (acc) begin
          widx_q <= widx_q + 1'b1;
          if (widx_q == 4'hF) begin
            bufs_q  <= bufs_q - 1'b1;
            state_q <= (bufs_q == BUF_W'(1)) ? S_CLR_RD : S_BUF_POLL;
          end
        end
        S_CLR_RD: if (acc) state_q <= S_CLR_WR;
        S_CLR_WR: if (acc) begin
          lba_q    <= lba_q + LBA_W'(chunk_q);
          remain_q <= remain_q - CNT_W'(chunk_q);
          state_q  <= (remain_q == CNT_W'(chunk_q)) ? S_REL_RD : S_LBA_LO;
        end
        S_REL_RD: if (acc) state_q <= S_REL_WR;
        S_REL_WR: if (acc) state_q <= S_FIN;
        S_FIN:    if (ser_ready) state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FIN) && ser_ready;
  assign err_code_o = err_q;
endmodule

// File: rtl/cf_sector_reader_chk.sv
module cf_sector_reader_chk
  import cf_rd_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        reg_req_o,
  input logic        reg_we_o,
  input logic [6:0]  reg_addr_o,
  input logic [15:0] reg_wdata_o,
  input logic        reg_ack_i,
  input logic        byte_valid_o,
  input logic [7:0]  byte_data_o,
  input logic        byte_ready_i
);
  a_r1_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o) && $stable(reg_we_o) && $stable(reg_wdata_o));

  a_r5_lba_hi_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_we_o && reg_addr_o == OFS_LBA_HI |-> reg_wdata_o[15:12] == 4'h0);

  a_r6_cmd_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_we_o && reg_addr_o == OFS_CMD |-> reg_wdata_o[15:8] == CMD_READ);

  a_r8_data_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_addr_o == OFS_DATA |-> !reg_we_o);

  a_r9_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_data_o));

  a_r9_read_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_addr_o == OFS_DATA |-> !byte_valid_o);

  a_r10_done_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o && !byte_valid_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind cf_sector_reader cf_sector_reader_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .reg_req_o(reg_req_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
  .reg_wdata_o(reg_wdata_o), .reg_ack_i(reg_ack_i),
  .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o), .byte_ready_i(byte_ready_i)
);

// File: tb/cf_sector_reader_tb_top.sv
module cf_sector_reader_tb_top;
  import cf_rd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CHUNK = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [27:0] lba = '0;
  logic [15:0] count = '0;
  logic        busy, done;
  logic [1:0]  err_code;
  logic        req, we, ack;
  logic [6:0]  addr;
  logic [15:0] wdata, rdata;
  logic        bvalid, bready;
  logic [7:0]  bdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cf_sector_reader #(
    .CYC_PER_US(1), .LOCK_RETRIES(3), .LOCK_GAP_US(5), .RDY_RETRIES(4),
    .RDY_GAP_US(3), .BUF_GAP_US(2), .CHUNK_MAX(CHUNK), .CNT_W(16), .LBA_W(28)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lba_i(lba), .count_i(count),
    .busy_o(busy), .done_o(done), .err_code_o(err_code),
    .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_ack_i(ack), .reg_rdata_i(rdata),
    .byte_valid_o(bvalid), .byte_data_o(bdata), .byte_ready_i(bready)
  );

  // controller model
  int          cfg_lock_after = 0, cfg_rdy_after = 0, cfg_drop_at = -1;
  logic        cfg_card = 1'b1, cfg_fast = 1'b0, clr_req = 1'b0;
  logic [15:0] cfg_seed = '0;
  logic [15:0] ctrl_m, word_ctr, stat;
  int          stat_reads;
  logic        ack_en;
  logic [7:0]  rdy_ctr;

  always_comb begin
    stat = '0;
    stat[1] = ctrl_m[1] && (stat_reads >= cfg_lock_after);
    stat[4] = cfg_card && !(cfg_drop_at >= 0 && stat_reads >= cfg_drop_at);
    stat[5] = stat_reads[0];
    stat[8] = (stat_reads >= cfg_rdy_after);
    case (addr)
      OFS_STAT: rdata = stat;
      OFS_CTRL: rdata = ctrl_m;
      OFS_DATA: rdata = word_ctr;
      default:  rdata = 16'h0;
    endcase
  end
  assign ack    = req && ack_en;
  assign bready = cfg_fast || (rdy_ctr[1:0] != 2'd0);

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_en <= 1'b0; rdy_ctr <= '0; ctrl_m <= 16'h0001; stat_reads <= 0; word_ctr <= '0;
    end else begin
      ack_en  <= ~ack_en;
      rdy_ctr <= rdy_ctr + 8'd1;
      if (clr_req) begin
        ctrl_m <= 16'h0001; stat_reads <= 0; word_ctr <= cfg_seed;
      end else if (req && ack) begin
        if (we && addr == OFS_CTRL) ctrl_m <= wdata;
        if (!we && addr == OFS_STAT) stat_reads <= stat_reads + 1;
        if (!we && addr == OFS_DATA) word_ctr <= word_ctr + 16'd1;
      end
    end
  end

  int n_chk = 0, n_err = 0;
  logic [7:0]  exp_bytes[$];
  logic [22:0] exp_wr[$];

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string wr_tag(input logic [6:0] a);
    case (a)
      OFS_LBA_LO, OFS_LBA_HI: return "R4/R5 lba write";
      OFS_CMD:                return "R6 command write";
      default:                return "R1/R7/R10 control write";
    endcase
  endfunction

  // monitor: scoreboard pops
  always @(negedge clk) begin
    if (rst_n && bvalid && bready) begin
      if (exp_bytes.size() == 0) chk(1'b0, "R8/R9 unexpected byte", bdata, 0);
      else begin
        logic [7:0] e;
        e = exp_bytes.pop_front();
        chk(bdata == e, "R8/R9 byte stream", bdata, e);
      end
    end
    if (rst_n && req && ack && we) begin
      if (exp_wr.size() == 0) chk(1'b0, "R2 unexpected write", {addr, wdata}, 0);
      else begin
        logic [22:0] e;
        e = exp_wr.pop_front();
        chk({addr, wdata} == e, wr_tag(e[22:16]), {addr, wdata}, e);
      end
    end
  end

  task automatic setup(input int lk, input int ry, input int drop, input logic card,
                       input logic fast, input logic [15:0] seed);
    @(negedge clk);
    cfg_lock_after = lk; cfg_rdy_after = ry; cfg_drop_at = drop;
    cfg_card = card; cfg_fast = fast; cfg_seed = seed; clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
  endtask

  // driver: pushes expected writes/bytes, starts, waits, checks result
  task automatic run(input logic [27:0] l0, input int cnt, input logic locked,
                     input logic [1:0] code, input int exp_reads, input string tag);
    logic [27:0] l;
    int rem, ch;
    logic [15:0] w;
    l = l0; rem = cnt; w = cfg_seed;
    exp_wr.push_back({OFS_CTRL, 16'h0003});
    if (locked) begin
      if (code == 2'd0) begin
        while (rem > 0) begin
          ch = (rem > CHUNK) ? CHUNK : rem;
          exp_wr.push_back({OFS_LBA_LO, l[15:0]});
          exp_wr.push_back({OFS_LBA_HI, 4'h0, l[27:16]});
          exp_wr.push_back({OFS_CMD, 8'h03, 8'(ch)});
          exp_wr.push_back({OFS_CTRL, 16'h0083});
          exp_wr.push_back({OFS_CTRL, 16'h0003});
          for (int k = 0; k < ch * 256; k++) begin
            exp_bytes.push_back(w[7:0]);
            exp_bytes.push_back(w[15:8]);
            w = w + 16'd1;
          end
          l = l + 28'(ch); rem = rem - ch;
        end
      end
      exp_wr.push_back({OFS_CTRL, 16'h0001});
    end
    @(negedge clk);
    lba = l0; count = 16'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(err_code == code, {tag, " error code"}, err_code, code);
    chk(exp_wr.size() == 0, {tag, " writes left"}, exp_wr.size(), 0);
    chk(exp_bytes.size() == 0, {tag, " bytes left"}, exp_bytes.size(), 0);
    chk(!busy, {tag, " idle after done"}, busy, 0);
    if (exp_reads >= 0) chk(stat_reads == exp_reads, {tag, " status polls"}, stat_reads, exp_reads);
    exp_wr.delete(); exp_bytes.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req && !bvalid && !done, "R1 reset state", {busy, req, bvalid, done}, 0);

    // R4 R5 R6 R7 R8 R9: five sectors in chunks 2,2,1, LBA carry, back-pressure
    setup(2, 4, -1, 1'b1, 1'b0, 16'hA5F0);
    run(28'hA12FFFF, 5, 1'b1, 2'd0, -1, "R4 multi-chunk");
    // R10: zero count still locks, polls ready, releases
    setup(0, 0, -1, 1'b1, 1'b1, 16'h0000);
    run(28'h0000040, 0, 1'b1, 2'd0, 2, "R10 zero count");
    // R2: lock never granted, card present -> code 1, no release
    setup(1000, 0, -1, 1'b1, 1'b0, 16'h0000);
    run(28'h0, 1, 1'b0, 2'd1, 4, "R2 lock timeout");
    // R2: lock never granted, card absent -> code 2
    setup(1000, 0, -1, 1'b0, 1'b0, 16'h0000);
    run(28'h0, 1, 1'b0, 2'd2, 4, "R2 card absent");
    // R3: card lost during ready poll -> code 2 with release
    setup(0, 1000, 2, 1'b1, 1'b0, 16'h0000);
    run(28'h0, 1, 1'b1, 2'd2, 3, "R3 card lost");
    // R3: never ready -> code 3 with release
    setup(0, 1000, -1, 1'b1, 1'b0, 16'h0000);
    run(28'h0, 1, 1'b1, 2'd3, 6, "R3 not ready");
    // R9: single sector, no back-pressure
    setup(0, 0, -1, 1'b1, 1'b1, 16'hFFF8);
    run(28'h0000123, 1, 1'b1, 2'd0, -1, "R9 one sector");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule